// File: doc/BRIEF.md
# Scan-Stream Transition Delay Slice

This block is one measurement slice of an I/O timing tester that works through a boundary-scan register. The capture latches of that register are clocked slightly off the update frequency, so each successive capture pass samples a tested pin a fixed fraction of a reference period later than the pass before. The captured register contents arrive at the slice one bit per beat. Each beat carries its bit position, taken from a position counter shared by every slice. The slice keeps the bit at its own programmed I/O address and ignores all other bits. It finds rising and falling transitions of that bit from one pass to the next. For each transition type, it counts passes from the transition seen under a first path or condition to the same transition seen under a second one.

A measurement has two phases of equal length. A start command clears the slice and runs phase one. The slice then holds its counts and waits, through any amount of test-port activity and through a test-port reset, until a phase-two command runs the second span. Between the two phases, a test pattern can switch drive strength, threshold or neighbour data by any means. The bits flow back toward the scan register on a second stream. They pass through unchanged, except at the tested position, where the slice substitutes a stimulus bit that alternates on each reload. Per-beat increment pulses are exported so that group-level average or maximum counters can OR the pulses of many slices together.

Top module: `scan_delay_slice`

## Requirements
- R1: The slice acts only on an accepted beat (`cap_valid` and `ret_ready` both high) whose `cap_pos` equals the loaded address, and only while a phase is running. Bits at other positions never change the counts.
- R2: `addr_load` copies `addr_in` into the address register only while no phase is running. A load request during a running phase is ignored.
- R3: A rising transition is a stored previous-pass bit of 0 followed by a current bit of 1 at the tested address. A falling transition is 1 followed by 0. The first matched pass of each phase has no previous bit, so it never reports a transition.
- R4: In phase one, a counter advances on each matched pass that comes after the first transition of its type in that phase. The pass on which that transition is seen does not advance it.
- R5: In phase two, a counter whose type was seen in phase one advances on each matched pass until the first transition of its type in phase two. From that pass on it stops. With P passes per phase, first-transition pass indices a (phase one, 1 ≤ a) and b (phase two), the count is (P-1-a)+b. If phase two shows no transition, the count is (P-1-a)+P. If phase one shows none, the count is 0.
- R6: Counters saturate at all ones and never wrap.
- R7: Each phase lasts P = N_STEPS × SPAN passes. A pass ends on the accepted beat at position SCAN_LEN-1. When phase one ends, `busy` falls and `phase1_done` rises.
- R8: `tap_rst` never changes the counts, the transition flags or `phase1_done`. It aborts a running phase: phase one returns to idle, and phase two returns to the waiting state.
- R9: Only `cmd_start` clears the counts, the flags, `phase1_done` and the stimulus bit. It then starts phase one. `cmd_phase2` is accepted only while waiting after phase one and is ignored otherwise.
- R10: The return stream mirrors the capture stream: `ret_valid` equals `cap_valid`, `cap_ready` equals `ret_ready`, and no state advances on a beat that is not accepted. `ret_data` equals `cap_data`, except at the tested address during a running phase, where it carries the stimulus bit. That bit is 1 on the first matched beat after a start and inverts on every accepted matched beat.
- R11: `rise_inc` and `fall_inc` are high for exactly the cycle in which the matching counter shows a new value, and at no other time.
- R12: `meas_done` rises once phase two has run all P passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan-side clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cmd_start | input | 1 | Clear slice and begin phase one |
| cmd_phase2 | input | 1 | Begin phase two after phase one |
| tap_rst | input | 1 | Test-port reset; aborts a run, keeps counts |
| addr_load | input | 1 | Load tested I/O address |
| addr_in | input | AW | Address to load |
| cap_valid | input | 1 | Captured bit present |
| cap_ready | output | 1 | Slice can accept captured bit |
| cap_data | input | 1 | Captured scan bit |
| cap_pos | input | AW | Shared position of the captured bit |
| ret_valid | output | 1 | Return bit present |
| ret_ready | input | 1 | Downstream accepts return bit |
| ret_data | output | 1 | Bit to shift back into the scan register |
| rise_cnt | output | CNT_W | Rising transition delay count |
| fall_cnt | output | CNT_W | Falling transition delay count |
| rise_inc | output | 1 | Rise counter advanced this cycle |
| fall_inc | output | 1 | Fall counter advanced this cycle |
| busy | output | 1 | A phase is running |
| phase1_done | output | 1 | Phase one finished since last start |
| meas_done | output | 1 | Both phases finished |

## Verification
The bench sweeps every pair of first-transition positions in both phases, for rising and for falling steps, on a five-bit register with eight passes per phase. Each result is compared with the closed formula, and a narrow counter makes half the results saturate. A design that counts the detecting pass, keeps counting after the phase-two transition, or compares the first bit of phase two with the last bit of phase one is off by one or more in many of those cases. A design that wraps produces small counts where the expected value is the all-ones ceiling. Neighbouring bits toggle on every pass, stalls and gaps are scattered through the stream, and an address load is attempted during every run. A slice that mis-decodes position, counts a refused beat, or lets the address move mid-run therefore shows wrong counts or wrong return data. The bench also pulses test-port reset between phases and in the middle of each phase, and checks that the counts survive and that a run is aborted as specified.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN1 = 3'd1,
    ST_HOLD = 3'd2,
    ST_RUN2 = 3'd3,
    ST_DONE = 3'd4
  } sdm_state_e;

  localparam int EDGE_KINDS = 2;
  localparam int EDGE_RISE  = 0;
  localparam int EDGE_FALL  = 1;

endpackage

// File: rtl/sdm_addr_match.sv
module sdm_addr_match #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          lock,
  input  logic [AW-1:0] pos,
  output logic          match
);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (load && !lock) addr_q <= addr_in;
  end

  assign match = (pos == addr_q);

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(addr_q)); // R2

endmodule

// File: rtl/sdm_edge_det.sv
module sdm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  input  logic bit_in,
  output logic rise,
  output logic fall
);

  logic prev_q;
  logic have_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (restart) begin
      have_prev_q <= 1'b0;
    end else if (step) begin
      prev_q      <= bit_in;
      have_prev_q <= 1'b1;
    end
  end

  assign rise = step && have_prev_q && !prev_q &&  bit_in;
  assign fall = step && have_prev_q &&  prev_q && !bit_in;

  // first matched pass of a phase cannot report a transition
  AST_FIRST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !(rise || fall)); // R3

endmodule

// File: rtl/sdm_delay_ctr.sv
module sdm_delay_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             second,
  input  logic             edge_now,
  output logic [CNT_W-1:0] cnt,
  output logic             inc
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             hit2_q;
  logic             inc_q;
  logic             adv;

  always_comb begin
    adv = step && seen_q && (cnt_q != CNT_MAX);
    if (second) adv = adv && !hit2_q && !edge_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      hit2_q <= 1'b0;
      inc_q  <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      hit2_q <= 1'b0;
      inc_q  <= 1'b0;
    end else begin
      inc_q <= adv;
      if (adv) cnt_q <= cnt_q + 1'b1;
      if (step && edge_now) begin
        if (second) hit2_q <= 1'b1;
        else        seen_q <= 1'b1;
      end
    end
  end

  assign cnt = cnt_q;
  assign inc = inc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && !clear |=> (cnt_q == CNT_MAX)); // R6
  AST_PULSE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (inc_q == (cnt_q != $past(cnt_q)))); // R11
  AST_PULSE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !step |=> !inc_q); // R1
  AST_STOPPED_IN_PHASE2: assert property (@(posedge clk) disable iff (!rst_n)
    second && hit2_q && !clear |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/sdm_seq.sv
module sdm_seq
  import sdm_pkg::*;
#(
  parameter int PASSES   = 16,
  parameter int SCAN_LEN = 16,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_phase2,
  input  logic          tap_rst,
  input  logic          beat,
  input  logic [AW-1:0] pos,
  output logic          running,
  output logic          second,
  output logic          clear,
  output logic          restart,
  output logic          p1_done,
  output logic          done
);

  localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;

  sdm_state_e    st_q, st_d;
  logic [PW-1:0] pass_q, pass_d;
  logic          p1_q, p1_d;
  logic          pass_end;
  logic          last_pass;
  logic          ph2_ok;

  assign running = (st_q == ST_RUN1) || (st_q == ST_RUN2);
  assign second  = (st_q == ST_RUN2);
  assign p1_done = p1_q;
  assign done    = (st_q == ST_DONE);

  always_comb begin
    pass_end  = beat && (pos == AW'(SCAN_LEN - 1));
    last_pass = (pass_q == PW'(PASSES - 1));
    clear     = cmd_start && !tap_rst;
    ph2_ok    = cmd_phase2 && !tap_rst && !cmd_start && (st_q == ST_HOLD);
    restart   = clear || ph2_ok;
    st_d      = st_q;
    pass_d    = pass_q;
    p1_d      = p1_q;
    if (tap_rst) begin
      pass_d = '0;
      if (st_q == ST_RUN1)      st_d = ST_IDLE;
      else if (st_q == ST_RUN2) st_d = ST_HOLD;
    end else if (clear) begin
      st_d   = ST_RUN1;
      pass_d = '0;
      p1_d   = 1'b0;
    end else if (ph2_ok) begin
      st_d   = ST_RUN2;
      pass_d = '0;
    end else if (running && pass_end) begin
      if (last_pass) begin
        pass_d = '0;
        if (st_q == ST_RUN1) begin
          st_d = ST_HOLD;
          p1_d = 1'b1;
        end else begin
          st_d = ST_DONE;
        end
      end else begin
        pass_d = pass_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= '0;
      p1_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      p1_q   <= p1_d;
    end
  end

  AST_PASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q <= PW'(PASSES - 1)); // R7
  AST_PHASE_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    p1_q && !clear |=> p1_q); // R8
  AST_TAP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    tap_rst |=> !running); // R8

endmodule

// File: rtl/scan_delay_slice.sv
module scan_delay_slice
  import sdm_pkg::*;
#(
  parameter int SCAN_LEN = 16,
  parameter int N_STEPS  = 8,
  parameter int SPAN     = 2,
  parameter int CNT_W    = 8,
  localparam int AW      = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_phase2,
  input  logic             tap_rst,
  input  logic             addr_load,
  input  logic [AW-1:0]    addr_in,
  input  logic             cap_valid,
  output logic             cap_ready,
  input  logic             cap_data,
  input  logic [AW-1:0]    cap_pos,
  output logic             ret_valid,
  input  logic             ret_ready,
  output logic             ret_data,
  output logic [CNT_W-1:0] rise_cnt,
  output logic [CNT_W-1:0] fall_cnt,
  output logic             rise_inc,
  output logic             fall_inc,
  output logic             busy,
  output logic             phase1_done,
  output logic             meas_done
);

  localparam int PASSES = N_STEPS * SPAN;

  logic beat;
  logic match;
  logic running;
  logic second;
  logic clr;
  logic restart;
  logic step;
  logic drive_q;
  logic [EDGE_KINDS-1:0] edge_v;
  logic [EDGE_KINDS-1:0] inc_v;
  logic [CNT_W-1:0]      cnt_v [EDGE_KINDS];

  // the return stream is a one-for-one mirror of the capture stream
  assign beat      = cap_valid && ret_ready;
  assign cap_ready = ret_ready;
  assign ret_valid = cap_valid;

  sdm_seq #(.PASSES(PASSES), .SCAN_LEN(SCAN_LEN), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_phase2(cmd_phase2),
    .tap_rst(tap_rst), .beat(beat), .pos(cap_pos), .running(running),
    .second(second), .clear(clr), .restart(restart), .p1_done(phase1_done),
    .done(meas_done)
  );

  sdm_addr_match #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .addr_in(addr_in),
    .lock(running), .pos(cap_pos), .match(match)
  );

  assign step = beat && match && running;

  sdm_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .bit_in(cap_data), .rise(edge_v[EDGE_RISE]), .fall(edge_v[EDGE_FALL])
  );

  for (genvar g = 0; g < EDGE_KINDS; g++) begin : g_ctr
    sdm_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clear(clr), .step(step), .second(second),
      .edge_now(edge_v[g]), .cnt(cnt_v[g]), .inc(inc_v[g])
    );
  end

  assign rise_cnt = cnt_v[EDGE_RISE];
  assign fall_cnt = cnt_v[EDGE_FALL];
  assign rise_inc = inc_v[EDGE_RISE];
  assign fall_inc = inc_v[EDGE_FALL];
  assign busy     = running;

  // stimulus bit for the tested position: alternates on every reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drive_q <= 1'b0;
    else if (clr)  drive_q <= 1'b0;
    else if (step) drive_q <= !drive_q;
  end

  assign ret_data = (match && running) ? !drive_q : cap_data;

  AST_REFUSED_BEAT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !beat && !cmd_start |=> $stable(rise_cnt) && $stable(fall_cnt)); // R10
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cmd_start |=> !rise_inc && !fall_inc); // R1

endmodule

// File: tb/scan_delay_slice_tb_top.sv
module scan_delay_slice_tb_top;

  localparam int LEN = 5;
  localparam int NS  = 4;
  localparam int SP  = 2;
  localparam int CW  = 3;
  localparam int P   = NS * SP;
  localparam int AW  = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_phase2 = 0, tap_rst = 0, addr_load = 0;
  logic [AW-1:0] addr_in = '0;
  logic cap_valid = 0, cap_data = 0, ret_ready = 1;
  logic [AW-1:0] cap_pos = '0;
  logic cap_ready, ret_valid, ret_data;
  logic [CW-1:0] rise_cnt, fall_cnt;
  logic rise_inc, fall_inc, busy, phase1_done, meas_done;

  int nchk = 0, nfail = 0;
  int rp_tot = 0, fp_tot = 0;
  int stall_ctr = 0;
  bit finished = 0;
  bit run_b = 0;
  bit drv_b = 0;
  int addr_b = 0;

  always #10 clk = ~clk;

  scan_delay_slice #(.SCAN_LEN(LEN), .N_STEPS(NS), .SPAN(SP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_phase2(cmd_phase2),
    .tap_rst(tap_rst), .addr_load(addr_load), .addr_in(addr_in),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_data(cap_data),
    .cap_pos(cap_pos), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_data(ret_data), .rise_cnt(rise_cnt), .fall_cnt(fall_cnt),
    .rise_inc(rise_inc), .fall_inc(fall_inc), .busy(busy),
    .phase1_done(phase1_done), .meas_done(meas_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rise_inc) rp_tot++;
      if (fall_inc) fp_tot++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // expected count for one transition type, indices 0 meaning none
  function automatic int expect_cnt(input int a, input int b);
    if (a == 0) return 0;
    return sat((P - 1 - a) + ((b == 0) ? P : b));
  endfunction

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one accepted beat, with scattered refusals and gaps
  task automatic do_beat(input int pos, input bit b);
    stall_ctr++;
    if (stall_ctr % 7 == 3) begin
      cap_valid = 1; cap_data = b; cap_pos = AW'(pos); ret_ready = 0;
      #2;
      chk(cap_ready == 0, "R10", "ready mirrors downstream", cap_ready, 0);
      @(posedge clk); @(negedge clk);
    end
    if (stall_ctr % 11 == 5) begin
      cap_valid = 0; ret_ready = 1;
      #2;
      chk(ret_valid == 0, "R10", "valid mirrors upstream", ret_valid, 0);
      @(posedge clk); @(negedge clk);
    end
    cap_valid = 1; cap_data = b; cap_pos = AW'(pos); ret_ready = 1;
    #2;
    if (run_b && pos == addr_b)
      chk(ret_data == !drv_b, "R10", "stimulus bit", ret_data, !drv_b);
    else
      chk(ret_data == b, "R10", "pass-through bit", ret_data, b);
    @(posedge clk);
    if (run_b && pos == addr_b) drv_b = !drv_b;
    @(negedge clk);
    cap_valid = 0;
  endtask

  function automatic bit pat(input int kind, input int r, input int p);
    bit v;
    v = (r == 0) ? 1'b0 : (p >= r);
    return kind ? !v : v;
  endfunction

  // one phase of P passes; optional mid-run address load attempt
  task automatic run_phase(input int kind, input int r, input bit try_load);
    for (int p = 0; p < P; p++) begin
      for (int b = 0; b < LEN; b++) begin
        if (try_load && p == 3 && b == 0) begin
          addr_load = 1; addr_in = AW'((addr_b + 1) % LEN);
        end
        do_beat(b, (b == addr_b) ? pat(kind, r, p) : bit'((p + b) & 1));
        addr_load = 0;
      end
    end
  endtask

  task automatic load_addr(input int a);
    addr_load = 1; addr_in = AW'(a);
    cycle();
    addr_load = 0;
    addr_b = a;
  endtask

  task automatic start_meas();
    cmd_start = 1;
    cycle();
    cmd_start = 0;
    run_b = 1; drv_b = 0;
  endtask

  task automatic run_case(input int kind, input int a, input int b, input int ad);
    int rp0, fp0, e_r, e_f;
    int hold_r, hold_f;
    load_addr(ad);
    rp0 = rp_tot; fp0 = fp_tot;
    start_meas();
    run_phase(kind, a, 1'b1);
    run_b = 0;
    #3;
    chk(busy == 0 && phase1_done == 1, "R7", "phase one end flags",
        {busy, phase1_done}, 1);
    hold_r = rise_cnt; hold_f = fall_cnt;
    tap_rst = 1;
    cycle();
    tap_rst = 0;
    #3;
    chk(rise_cnt == hold_r && fall_cnt == hold_f && phase1_done == 1, "R8",
        "counts kept over test-port reset", rise_cnt, hold_r);
    @(negedge clk);
    cmd_phase2 = 1;
    cycle();
    cmd_phase2 = 0;
    run_b = 1;
    run_phase(kind, b, 1'b0);
    run_b = 0;
    cycle();
    #3;
    e_r = (kind == 0) ? expect_cnt(a, b) : 0;
    e_f = (kind == 1) ? expect_cnt(a, b) : 0;
    chk(rise_cnt == e_r, "R5", "rise count", rise_cnt, e_r);
    chk(fall_cnt == e_f, "R4", "fall count", fall_cnt, e_f);
    chk(meas_done == 1, "R12", "measurement done", meas_done, 1);
    chk(rp_tot - rp0 == e_r, "R11", "rise pulse total", rp_tot - rp0, e_r);
    chk(fp_tot - fp0 == e_f, "R11", "fall pulse total", fp_tot - fp0, e_f);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int hr, hf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #3;
    chk(rise_cnt == 0 && fall_cnt == 0, "R9", "reset counts", rise_cnt, 0);
    chk(busy == 0 && phase1_done == 0 && meas_done == 0, "R7", "reset flags",
        {busy, phase1_done, meas_done}, 0);
    @(negedge clk);

    // phase two command before any phase one: ignored
    cmd_phase2 = 1;
    cycle();
    cmd_phase2 = 0;
    #3;
    chk(busy == 0, "R9", "early phase-two command ignored", busy, 0);
    @(negedge clk);

    // abort in phase one
    load_addr(2);
    start_meas();
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < LEN; b++) do_beat(b, bit'(p == 1));
    tap_rst = 1;
    cycle();
    tap_rst = 0; run_b = 0;
    #3;
    chk(busy == 0 && phase1_done == 0, "R8", "abort in phase one",
        {busy, phase1_done}, 0);
    @(negedge clk);

    // abort in phase two keeps counts, then phase two restarts
    start_meas();
    run_phase(0, 2, 1'b0);
    cmd_phase2 = 1;
    cycle();
    cmd_phase2 = 0;
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < LEN; b++) do_beat(b, 1'b0);
    #3;
    hr = rise_cnt; hf = fall_cnt;
    @(negedge clk);
    tap_rst = 1;
    cycle();
    tap_rst = 0; run_b = 0;
    repeat (3) cycle();
    #3;
    chk(busy == 0 && phase1_done == 1, "R8", "abort in phase two", busy, 0);
    chk(rise_cnt == hr && fall_cnt == hf, "R8", "counts kept after abort",
        rise_cnt, hr);
    @(negedge clk);
    cmd_phase2 = 1;
    cycle();
    cmd_phase2 = 0;
    #3;
    chk(busy == 1, "R9", "phase two accepted while waiting", busy, 1);
    @(negedge clk);
    cmd_start = 1;
    cycle();
    cmd_start = 0;
    #3;
    chk(rise_cnt == 0 && phase1_done == 0, "R9", "start clears", rise_cnt, 0);
    @(negedge clk);
    tap_rst = 1;
    cycle();
    tap_rst = 0;

    // exhaustive sweep of first-transition positions, both types
    for (int kind = 0; kind < 2; kind++)
      for (int a = 0; a < P; a++)
        for (int b = 0; b < P; b++)
          run_case(kind, a, b, (a + 2 * b + kind) % LEN);

    report();
  end

endmodule